// File: doc/BRIEF.md
# Microcontroller Bus Address Decoder

This block decodes the external bus of an 8-bit microcontroller whose low address byte is multiplexed with data. It takes the low byte from the shared bus whenever the address-latch-enable input is high and holds it on its own outputs. It combines that byte with the high address byte and with the program-fetch, data-read and data-write strobes. From these it drives active-low chip enables for an EPROM, two 16K RAM blocks, a UART, a parallel peripheral chip and an expansion block. It also drives four strobe-only bit ports. It generates one shared read enable for the memories and the masked EPROM address lines.

The RAM block at 4000h–7FFFh can be read as both program and data memory, so code loaded as data can then be run. The RAM block at 0000h–3FFFh is data memory only. The EPROM is split into two 16K halves, one decoded at 0000h and one at 8000h.

A programming mode lets three port lines take over three outputs: the EPROM enable, the system ALE output and the active-low programming-voltage enable. In this mode the EPROM can be written with a programming pulse.

Top module: `mcu_bus_decoder`

## Requirements
- R1: `a_lo_o` is cleared by reset. On every rising clock edge where `ale_i` is high it loads `ad_i`, and otherwise it holds its value.
- R2: When `ea_n_i` is high, a fetch (`psen_n_i` low) below 2000h asserts no chip enable. When `ea_n_i` is low, the same fetch selects the EPROM.
- R3: `rom_ce_n_o` is low in three cases: a fetch at 0000h–3FFFh (subject to R2), a fetch at 8000h–BFFFh, and a data read at 8000h–BFFFh. It is never low on a data write or on a data read below 8000h.
- R4: `ram_c_ce_n_o` is low for any fetch, data read or data write at 4000h–7FFFh.
- R5: `ram_d_ce_n_o` is low for a data read or write at 0000h–3FFFh and never on a fetch.
- R6: For a data read or write, `uart_cs_n_o` is low at F000h–F3FFh, `ppi_cs_n_o` is low at F400h–F7FFh and `iox_cs_n_o` is low at F800h–F8FFh. None of them is low on a fetch.
- R7: `bitp_n_o[i]` is low only during a data read or write whose high address byte equals FCh+i, whatever the low byte.
- R8: No enable is low at C000h–EFFFh, at F900h–FBFFh, for a fetch at C000h or above, or when no strobe is active. The access kind follows this priority: `psen_n_i` low means a fetch; otherwise `rd_n_i` low means a read; otherwise `wr_n_i` low means a write.
- R9: `mem_oe_n_o` is low exactly when a fetch or data read selects the EPROM or either RAM.
- R10: Outside programming mode, at most one of the ten enables is low in any cycle.
- R11: `rom_a_o[12:0]` equals address bits 12:0. `rom_a_o[13]` is address bit 13, forced to 0 when `rom_size_i`=0 (8K). `rom_a_o[14]` is address bit 15, kept only when `rom_size_i` is 2 or 3 (32K) and forced to 0 otherwise (`rom_size_i`=1 is 16K).
- R12: With `prg_mode_n_i` low: `rom_ce_n_o` follows `prg_pulse_n_i`; `sys_ale_o` is `ale_i` gated off by `prg_ale_off_i` high; `vpp_n_o` follows `prg_vpp_n_i`.
- R13: With `prg_mode_n_i` high, `sys_ale_o` follows `ale_i`, `vpp_n_o` stays high, and the three port lines have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ale_i | input | 1 | Address latch enable from the controller |
| ad_i | input | 8 | Multiplexed low address/data bus |
| a_hi_i | input | 8 | High address byte |
| psen_n_i | input | 1 | Program-fetch strobe, active low |
| rd_n_i | input | 1 | Data-read strobe, active low |
| wr_n_i | input | 1 | Data-write strobe, active low |
| ea_n_i | input | 1 | Low: all fetches external |
| rom_size_i | input | 2 | EPROM size: 0=8K, 1=16K, 2/3=32K |
| prg_mode_n_i | input | 1 | Low: EPROM programming mode |
| prg_ale_off_i | input | 1 | Programming: high suppresses system ALE |
| prg_pulse_n_i | input | 1 | Programming: EPROM enable pulse |
| prg_vpp_n_i | input | 1 | Programming: voltage enable request, active low |
| a_lo_o | output | 8 | Captured low address byte |
| rom_a_o | output | 15 | EPROM address lines, masked by size |
| sys_ale_o | output | 1 | System ALE |
| rom_ce_n_o | output | 1 | EPROM chip enable |
| ram_c_ce_n_o | output | 1 | Shared program/data RAM enable |
| ram_d_ce_n_o | output | 1 | Data-only RAM enable |
| mem_oe_n_o | output | 1 | Memory read enable |
| uart_cs_n_o | output | 1 | UART select |
| ppi_cs_n_o | output | 1 | Parallel peripheral select |
| iox_cs_n_o | output | 1 | Expansion block select |
| bitp_n_o | output | 4 | Bit-port strobes |
| vpp_n_o | output | 1 | Programming-voltage enable, active low |

## Verification
The bound checker watches several properties on every cycle: the low-byte load and hold, the one-hot rule on the enables, the rule that a bit-port strobe needs a data strobe, the rule that the data-only RAM never answers a fetch, the rule that the EPROM never answers a write, and the programming-mode pass-throughs. Only the bench's scenarios can show the exact address windows, the internal-fetch cutoff at 2000h, the EPROM size masking and the unused holes. The bench sweeps every high address byte under each access kind and both fetch-source settings.

// File: rtl/busdec_pkg.sv
`timescale 1ns/1ps
package busdec_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE   = 2'd0,
      ACC_FETCH  = 2'd1,
      ACC_DREAD  = 2'd2,
      ACC_DWRITE = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      ROM_8K   = 2'd0,
      ROM_16K  = 2'd1,
      ROM_32K  = 2'd2,
      ROM_32KB = 2'd3
   } rom_size_e;

   // select vector bit positions
   localparam int SEL_ROM   = 0;
   localparam int SEL_RAMC  = 1;
   localparam int SEL_RAMD  = 2;
   localparam int SEL_UART  = 3;
   localparam int SEL_PPI   = 4;
   localparam int SEL_IOX   = 5;
   localparam int SEL_BITP0 = 6;

   localparam logic [7:0] BITP_BASE = 8'hFC;
   localparam logic [7:0] IOX_PAGE  = 8'hF8;
   localparam logic [5:0] UART_KB   = 6'b111100;
   localparam logic [5:0] PPI_KB    = 6'b111101;

endpackage

// File: rtl/busdec_lo_latch.sv
`timescale 1ns/1ps
module busdec_lo_latch #(
   parameter int LO_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ale_i,
   input  logic [LO_W-1:0] ad_i,
   output logic [LO_W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= '0;
      else if (ale_i) q_o <= ad_i;
   end
endmodule

// File: rtl/busdec_access.sv
`timescale 1ns/1ps
module busdec_access
   import busdec_pkg::*;
(
   input  logic psen_n_i,
   input  logic rd_n_i,
   input  logic wr_n_i,
   output acc_e acc_o
);
   always_comb begin
      if (!psen_n_i)    acc_o = ACC_FETCH;
      else if (!rd_n_i) acc_o = ACC_DREAD;
      else if (!wr_n_i) acc_o = ACC_DWRITE;
      else              acc_o = ACC_IDLE;
   end
endmodule

// File: rtl/busdec_map.sv
`timescale 1ns/1ps
module busdec_map
   import busdec_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int N_BITP = 4,
   localparam int SEL_W = SEL_BITP0 + N_BITP,
   localparam int ROM_W = ADDR_W - 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  acc_e              acc_i,
   input  logic              ea_n_i,
   input  logic [1:0]        rom_size_i,
   output logic [SEL_W-1:0]  sel_o,
   output logic [ROM_W-1:0]  rom_a_o
);
   localparam logic [ADDR_W-1:0] INT_TOP = ADDR_W'(1) << (ADDR_W - 3);

   logic [1:0] quarter;
   logic [7:0] page;
   logic       fetch, dread, dacc, internal;

   assign quarter  = addr_i[ADDR_W-1 -: 2];
   assign page     = addr_i[ADDR_W-1 -: 8];
   assign fetch    = (acc_i == ACC_FETCH);
   assign dread    = (acc_i == ACC_DREAD);
   assign dacc     = dread || (acc_i == ACC_DWRITE);
   assign internal = ea_n_i && (addr_i < INT_TOP);

   assign sel_o[SEL_ROM]  = (fetch && ((quarter == 2'd0 && !internal) || quarter == 2'd2))
                         || (dread && quarter == 2'd2);
   assign sel_o[SEL_RAMC] = (quarter == 2'd1) && (acc_i != ACC_IDLE);
   assign sel_o[SEL_RAMD] = (quarter == 2'd0) && dacc;
   assign sel_o[SEL_UART] = dacc && (page[7:2] == UART_KB);
   assign sel_o[SEL_PPI]  = dacc && (page[7:2] == PPI_KB);
   assign sel_o[SEL_IOX]  = dacc && (page == IOX_PAGE);

   for (genvar i = 0; i < N_BITP; i++) begin : g_bitp
      assign sel_o[SEL_BITP0+i] = dacc && (page == 8'(BITP_BASE + i));
   end

   // EPROM address: lower half maps to part 0..3FFF, upper half to 4000..7FFF
   assign rom_a_o[ROM_W-3:0] = addr_i[ROM_W-3:0];
   assign rom_a_o[ROM_W-2]   = addr_i[ROM_W-2] && (rom_size_i != ROM_8K);
   assign rom_a_o[ROM_W-1]   = addr_i[ADDR_W-1] && rom_size_i[1];
endmodule

// File: rtl/busdec_prog_ovr.sv
`timescale 1ns/1ps
module busdec_prog_ovr (
   input  logic prg_mode_n_i,
   input  logic ale_i,
   input  logic prg_ale_off_i,
   input  logic prg_pulse_n_i,
   input  logic prg_vpp_n_i,
   input  logic rom_sel_i,
   output logic rom_ce_n_o,
   output logic sys_ale_o,
   output logic vpp_n_o
);
   always_comb begin
      if (!prg_mode_n_i) begin
         rom_ce_n_o = prg_pulse_n_i;
         sys_ale_o  = ale_i && !prg_ale_off_i;
         vpp_n_o    = prg_vpp_n_i;
      end else begin
         rom_ce_n_o = !rom_sel_i;
         sys_ale_o  = ale_i;
         vpp_n_o    = 1'b1;
      end
   end
endmodule

// File: rtl/mcu_bus_decoder.sv
`timescale 1ns/1ps
module mcu_bus_decoder
   import busdec_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int N_BITP = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ale_i,
   input  logic [ADDR_W/2-1:0] ad_i,
   input  logic [ADDR_W/2-1:0] a_hi_i,
   input  logic                psen_n_i,
   input  logic                rd_n_i,
   input  logic                wr_n_i,
   input  logic                ea_n_i,
   input  logic [1:0]          rom_size_i,
   input  logic                prg_mode_n_i,
   input  logic                prg_ale_off_i,
   input  logic                prg_pulse_n_i,
   input  logic                prg_vpp_n_i,
   output logic [ADDR_W/2-1:0] a_lo_o,
   output logic [ADDR_W-2:0]   rom_a_o,
   output logic                sys_ale_o,
   output logic                rom_ce_n_o,
   output logic                ram_c_ce_n_o,
   output logic                ram_d_ce_n_o,
   output logic                mem_oe_n_o,
   output logic                uart_cs_n_o,
   output logic                ppi_cs_n_o,
   output logic                iox_cs_n_o,
   output logic [N_BITP-1:0]   bitp_n_o,
   output logic                vpp_n_o
);
   localparam int LO_W  = ADDR_W / 2;
   localparam int SEL_W = SEL_BITP0 + N_BITP;

   if (ADDR_W != 16) begin : g_bad_addr
      $error("mcu_bus_decoder: memory map assumes a 16-bit address");
   end
   if (N_BITP < 1 || N_BITP > 4) begin : g_bad_bitp
      $error("mcu_bus_decoder: N_BITP must be 1..4");
   end

   logic [LO_W-1:0]  lo_q;
   logic [SEL_W-1:0] sel;
   acc_e             acc;
   logic             rd_kind;

   busdec_lo_latch #(.LO_W(LO_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .ad_i(ad_i), .q_o(lo_q)
   );

   busdec_access u_acc (
      .psen_n_i(psen_n_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .acc_o(acc)
   );

   busdec_map #(.ADDR_W(ADDR_W), .N_BITP(N_BITP)) u_map (
      .addr_i({a_hi_i, lo_q}), .acc_i(acc), .ea_n_i(ea_n_i),
      .rom_size_i(rom_size_i), .sel_o(sel), .rom_a_o(rom_a_o)
   );

   busdec_prog_ovr u_ovr (
      .prg_mode_n_i(prg_mode_n_i), .ale_i(ale_i), .prg_ale_off_i(prg_ale_off_i),
      .prg_pulse_n_i(prg_pulse_n_i), .prg_vpp_n_i(prg_vpp_n_i),
      .rom_sel_i(sel[SEL_ROM]), .rom_ce_n_o(rom_ce_n_o),
      .sys_ale_o(sys_ale_o), .vpp_n_o(vpp_n_o)
   );

   assign rd_kind      = (acc == ACC_FETCH) || (acc == ACC_DREAD);
   assign a_lo_o       = lo_q;
   assign ram_c_ce_n_o = !sel[SEL_RAMC];
   assign ram_d_ce_n_o = !sel[SEL_RAMD];
   assign mem_oe_n_o   = !(rd_kind && (sel[SEL_ROM] || sel[SEL_RAMC] || sel[SEL_RAMD]));
   assign uart_cs_n_o  = !sel[SEL_UART];
   assign ppi_cs_n_o   = !sel[SEL_PPI];
   assign iox_cs_n_o   = !sel[SEL_IOX];
   assign bitp_n_o     = ~sel[SEL_W-1:SEL_BITP0];
endmodule

// File: rtl/busdec_chk.sv
`timescale 1ns/1ps
module busdec_chk #(
   parameter int N_BITP = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ale_i,
   input logic [7:0]        ad_i,
   input logic              psen_n_i,
   input logic              rd_n_i,
   input logic              wr_n_i,
   input logic              prg_mode_n_i,
   input logic              prg_pulse_n_i,
   input logic [7:0]        a_lo_o,
   input logic              rom_ce_n_o,
   input logic              ram_c_ce_n_o,
   input logic              ram_d_ce_n_o,
   input logic              uart_cs_n_o,
   input logic              ppi_cs_n_o,
   input logic              iox_cs_n_o,
   input logic [N_BITP-1:0] bitp_n_o,
   input logic              vpp_n_o
);
   // R1
   lo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale_i |=> (a_lo_o == $past(ad_i)));
   // R1
   lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ale_i |=> $stable(a_lo_o));
   // R10
   enable_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prg_mode_n_i |-> $onehot0(~{bitp_n_o, iox_cs_n_o, ppi_cs_n_o, uart_cs_n_o,
                                   ram_d_ce_n_o, ram_c_ce_n_o, rom_ce_n_o}));
   // R7
   bitp_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bitp_n_o != '1) |-> (!rd_n_i || !wr_n_i));
   // R5
   ramd_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !psen_n_i |-> ram_d_ce_n_o);
   // R3
   rom_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prg_mode_n_i && psen_n_i && rd_n_i) |-> rom_ce_n_o);
   // R12
   prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !prg_mode_n_i |-> (rom_ce_n_o == prg_pulse_n_i));
   // R13
   normal_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prg_mode_n_i |-> vpp_n_o);
endmodule

bind mcu_bus_decoder busdec_chk #(.N_BITP(N_BITP)) u_chk (
   .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .ad_i(ad_i),
   .psen_n_i(psen_n_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
   .prg_mode_n_i(prg_mode_n_i), .prg_pulse_n_i(prg_pulse_n_i),
   .a_lo_o(a_lo_o), .rom_ce_n_o(rom_ce_n_o), .ram_c_ce_n_o(ram_c_ce_n_o),
   .ram_d_ce_n_o(ram_d_ce_n_o), .uart_cs_n_o(uart_cs_n_o), .ppi_cs_n_o(ppi_cs_n_o),
   .iox_cs_n_o(iox_cs_n_o), .bitp_n_o(bitp_n_o), .vpp_n_o(vpp_n_o)
);

// File: tb/mcu_bus_decoder_bench.sv
`timescale 1ns/1ps
module mcu_bus_decoder_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ale_i = 1'b0;
   logic [7:0] ad_i = '0, a_hi_i = '0;
   logic psen_n_i = 1'b1, rd_n_i = 1'b1, wr_n_i = 1'b1, ea_n_i = 1'b1;
   logic [1:0] rom_size_i = 2'd2;
   logic prg_mode_n_i = 1'b1, prg_ale_off_i = 1'b0, prg_pulse_n_i = 1'b1, prg_vpp_n_i = 1'b1;
   logic [7:0] a_lo_o;
   logic [14:0] rom_a_o;
   logic sys_ale_o, rom_ce_n_o, ram_c_ce_n_o, ram_d_ce_n_o, mem_oe_n_o;
   logic uart_cs_n_o, ppi_cs_n_o, iox_cs_n_o, vpp_n_o;
   logic [3:0] bitp_n_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   mcu_bus_decoder u_mcu_bus_decoder (.*);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // expected selects: bit0 rom,1 shared ram,2 data ram,3 uart,4 ppi,5 iox,6..9 bit ports
   function automatic logic [9:0] exp_sel(input logic [15:0] a, input int s, input bit ea);
      logic [9:0] v;
      bit f, r, d, intl;
      logic [1:0] q;
      logic [7:0] h;
      f = (s == 1); r = (s == 2); d = (s == 2) || (s == 3);
      q = a[15:14]; h = a[15:8];
      intl = ea && (a < 16'h2000);
      v = '0;
      v[0] = (f && ((q == 0 && !intl) || q == 2)) || (r && q == 2);
      v[1] = (q == 1) && (s != 0);
      v[2] = (q == 0) && d;
      v[3] = d && (h >= 8'hF0) && (h <= 8'hF3);
      v[4] = d && (h >= 8'hF4) && (h <= 8'hF7);
      v[5] = d && (h == 8'hF8);
      for (int i = 0; i < 4; i++) v[6+i] = d && (h == 8'hFC + i);
      return v;
   endfunction

   function automatic logic [9:0] obs_sel();
      return ~{bitp_n_o, iox_cs_n_o, ppi_cs_n_o, uart_cs_n_o, ram_d_ce_n_o, ram_c_ce_n_o, rom_ce_n_o};
   endfunction

   // s: 0 idle, 1 fetch, 2 data read, 3 data write
   task automatic access(input logic [15:0] a, input int s, input bit ea);
      @(posedge clk); #1;
      psen_n_i = 1; rd_n_i = 1; wr_n_i = 1;
      ale_i = 1; ad_i = a[7:0];
      @(posedge clk); #1;
      ale_i = 0; ad_i = ~a[7:0]; a_hi_i = a[15:8]; ea_n_i = ea;
      psen_n_i = !(s == 1); rd_n_i = !(s == 2); wr_n_i = !(s == 3);
      #4;
   endtask

   task automatic check_access(input logic [15:0] a, input int s, input bit ea);
      logic [9:0] e, o;
      string tg [10];
      logic [14:0] ra;
      tg = '{"R3", "R4", "R5", "R6", "R6", "R6", "R7", "R7", "R7", "R7"};
      e = exp_sel(a, s, ea);
      o = obs_sel();
      for (int i = 0; i < 10; i++) begin
         if (i == 0 && s == 1 && ea && a < 16'h2000)
            chk(o[0] == e[0], "R2 internal fetch", 32'(o[0]), 32'(e[0]));
         else
            chk(o[i] == e[i], $sformatf("%s sel%0d addr=%h kind=%0d", tg[i], i, a, s), 32'(o[i]), 32'(e[i]));
      end
      // R10
      chk($countones(o) <= 1, "R10 onehot", 32'(o), 32'(e));
      // R8
      if ((a >= 16'hC000 && a < 16'hF000) || (a >= 16'hF900 && a < 16'hFC00) || s == 0)
         chk(o == '0, $sformatf("R8 hole addr=%h kind=%0d", a, s), 32'(o), 32'h0);
      // R9
      chk(mem_oe_n_o == !((s == 1 || s == 2) && (e[0] || e[1] || e[2])),
          "R9 mem oe", 32'(mem_oe_n_o), 32'(!((s == 1 || s == 2) && (e[0] || e[1] || e[2]))));
      // R1
      chk(a_lo_o == a[7:0], "R1 low byte", 32'(a_lo_o), 32'(a[7:0]));
      // R11
      ra = {a[15] && rom_size_i[1], a[13] && (rom_size_i != 2'd0), a[12:0]};
      chk(rom_a_o == ra, "R11 rom addr", 32'(rom_a_o), 32'(ra));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #4;
      // R1 reset state, R8 idle
      chk(a_lo_o == 8'h00, "R1 reset low byte", 32'(a_lo_o), 0);
      chk(obs_sel() == '0, "R8 reset enables", 32'(obs_sel()), 0);
      @(posedge clk); #1 rst_n = 1;

      // sweep of high byte, access kinds and fetch-source
      for (int h = 0; h < 256; h++) begin
         for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 2; e++) begin
               logic [15:0] a;
               a = {8'(h), 8'(h) ^ 8'h5A};
               rom_size_i = 2'((h + s) % 4);
               access(a, s, e[0]);
               check_access(a, s, e[0]);
            end
         end
      end

      // boundary directed cases
      rom_size_i = 2'd2;
      access(16'h1FFF, 1, 1'b1); check_access(16'h1FFF, 1, 1'b1);  // R2
      access(16'h2000, 1, 1'b1); check_access(16'h2000, 1, 1'b1);  // R2, R3
      access(16'h1FFF, 1, 1'b0); check_access(16'h1FFF, 1, 1'b0);  // R2
      access(16'hBFFF, 3, 1'b0); check_access(16'hBFFF, 3, 1'b0);  // R3 write
      access(16'hFCFF, 2, 1'b0); check_access(16'hFCFF, 2, 1'b0);  // R7
      access(16'hF8FF, 3, 1'b0); check_access(16'hF8FF, 3, 1'b0);  // R6
      access(16'hF900, 2, 1'b0); check_access(16'hF900, 2, 1'b0);  // R8

      // R1 hold: ALE low, bus changes, byte stays
      @(posedge clk); #1 ad_i = 8'h33;
      @(posedge clk); #4;
      chk(a_lo_o == 8'h00, "R1 hold without ALE", 32'(a_lo_o), 32'h00);

      // R13: port lines ignored outside programming mode
      psen_n_i = 1; rd_n_i = 1; wr_n_i = 1;
      prg_pulse_n_i = 0; prg_vpp_n_i = 0; prg_ale_off_i = 1; ale_i = 1;
      #1;
      chk(rom_ce_n_o == 1'b1, "R13 pulse ignored", 32'(rom_ce_n_o), 1);
      chk(vpp_n_o == 1'b1, "R13 vpp high", 32'(vpp_n_o), 1);
      chk(sys_ale_o == 1'b1, "R13 ale passes", 32'(sys_ale_o), 1);
      @(posedge clk); #1 ale_i = 0;

      // R12: programming mode
      prg_mode_n_i = 0;
      prg_pulse_n_i = 0; prg_vpp_n_i = 0; prg_ale_off_i = 1; ale_i = 1;
      #1;
      chk(rom_ce_n_o == 1'b0, "R12 pulse low", 32'(rom_ce_n_o), 0);
      chk(vpp_n_o == 1'b0, "R12 vpp on", 32'(vpp_n_o), 0);
      chk(sys_ale_o == 1'b0, "R12 ale suppressed", 32'(sys_ale_o), 0);
      prg_pulse_n_i = 1; prg_vpp_n_i = 1; prg_ale_off_i = 0;
      #1;
      chk(rom_ce_n_o == 1'b1, "R12 pulse high", 32'(rom_ce_n_o), 1);
      chk(vpp_n_o == 1'b1, "R12 vpp off", 32'(vpp_n_o), 1);
      chk(sys_ale_o == 1'b1, "R12 ale passes", 32'(sys_ale_o), 1);
      @(posedge clk); #1 ale_i = 0; prg_mode_n_i = 1;
      @(posedge clk); #4;

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule